// File: doc/BRIEF.md
# Interval Timer Bank

The block holds three reloadable down-counters and one wide free-running up-counter, all clocked by a single system clock. Counting is paced by two single-cycle tick enables: a slow tick of about 508 kHz and a fast tick of 983.04 kHz. Both are generated outside the block. Software programs the timers through a small word-addressed write/read port.

Each down-counter has four word slots: a reload value, a live count, a control word and an acknowledge slot. When a down-counter passes zero it raises its own level interrupt, which stays high until software writes to the acknowledge slot. In periodic mode the counter then reloads. In free-run mode it wraps to all ones.

The up-counter never interrupts. Software reads it as a low word and a high word, and it starts counting when bit 8 of the high word is written as one. A typical use pairs a periodic down-counter, which gives the operating system its tick, with the up-counter, which measures elapsed time between interrupts.

Top module: `timer_bank`

## Requirements
- R1: After reset, every counter, reload value, control word, enable and interrupt is zero, and every readable address returns zero.
- R2: Writing word offset 0 of a down-counter stores the reload value and copies it into the live count in the same cycle, whether or not the timer is enabled. The live count is readable at offset 1.
- R3: The control word sits at offset 2. Bit 7 enables the timer, bit 6 selects periodic mode, and bit 3 selects the pacing tick (1 = slow tick, 0 = fast tick). All other control bits read as zero.
- R4: An enabled down-counter decrements by one on each selected tick. A disabled counter holds its value whatever the ticks do.
- R5: In periodic mode with reload value N, the interrupt rises on tick N+1 after the load. The count then restarts from N, so every later period is also N+1 ticks.
- R6: In free-run mode, an underflow sets the interrupt and wraps the count to all ones without reloading.
- R7: Each interrupt is a level that stays high until any value is written to offset 3 of that timer. If an underflow falls in the same cycle as that write, the interrupt stays high.
- R8: Timer k (k = 0, 1, 2) starts at word address 4k. Timers 0 and 1 are SHORT_W bits wide and timer 2 is LONG_W bits wide. Writes keep only the low bits and reads are zero-extended. A timer's interrupt is unaffected by the other timers.
- R9: The up-counter's low LO_W bits read at address 12. Address 13 reads the enable in bit 8 and the counter bits above LO_W in bits 7:0. Writing address 13 sets the enable from bit 8. When enabled, the counter adds one per fast tick and ignores the slow tick.
- R10: The up-counter wraps from all ones to zero, and the low word carries into the high word.
- R11: Addresses 14 and 15 read zero, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| slow_tick | input | 1 | Single-cycle enable at the slow rate |
| fast_tick | input | 1 | Single-cycle enable at the fast rate |
| wr_en | input | 1 | Write strobe for the addressed word |
| addr | input | 4 | Word address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| irq | output | 3 | Level interrupt of each down-counter |

## Verification
The bench builds the block with SHORT_W=4, LONG_W=6, FREE_W=12 and LO_W=8. With these widths every reload value of the short timers can be swept, and the full period of the wide timer fits in a few dozen ticks. They also bring both the low-to-high carry and the complete wrap of the up-counter within a few thousand ticks. Every period and count the bench expects is derived from the load value and the number of ticks it has issued.

// File: rtl/timer_pkg.sv
// Shared constants for the timer bank: word map and control bit positions.
// Assumes a 4-bit word address and a 32-bit data path.
package timer_pkg;
    localparam int WORD_W     = 32;
    localparam int ADDR_W     = 4;
    localparam int N_DOWN     = 3;
    // offsets inside a down-counter's four-word slot
    localparam int OFS_LOAD   = 0;
    localparam int OFS_VALUE  = 1;
    localparam int OFS_CTRL   = 2;
    localparam int OFS_ACK    = 3;
    // up-counter words
    localparam int ADR_UP_LO  = 12;
    localparam int ADR_UP_HI  = 13;
    // control word bits
    localparam int CB_RUN     = 7;
    localparam int CB_PERIOD  = 6;
    localparam int CB_SLOW    = 3;
    localparam int UP_EN_BIT  = 8;
endpackage

// File: rtl/tmr_decode.sv
// Write decoder: turns a word address plus write strobe into one-hot
// per-register strobes. Assumes the map of timer_pkg; unmapped words
// produce no strobe.
module tmr_decode
    import timer_pkg::*;
#(
    parameter int NT = N_DOWN
) (
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    output logic [NT-1:0]     load_we,
    output logic [NT-1:0]     ctrl_we,
    output logic [NT-1:0]     ack_we,
    output logic              up_we
);
    // per-timer strobes from the slot index and the word offset
    for (genvar k = 0; k < NT; k++) begin : g_slot
        always_comb begin
            load_we[k] = wr_en && (int'(addr) == 4*k + OFS_LOAD);
            ctrl_we[k] = wr_en && (int'(addr) == 4*k + OFS_CTRL);
            ack_we[k]  = wr_en && (int'(addr) == 4*k + OFS_ACK);
        end
    end

    // enable word of the up-counter
    assign up_we = wr_en && (int'(addr) == ADR_UP_HI);
endmodule

// File: rtl/tmr_down.sv
// One reloadable down-counter with a level interrupt on underflow.
// Assumes ticks are single-cycle enables in the clk domain and W <= 32.
module tmr_down #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         slow_tick,
    input  logic         fast_tick,
    input  logic         load_we,
    input  logic [W-1:0] load_data,
    input  logic         ctrl_we,
    input  logic         ctrl_run,
    input  logic         ctrl_period,
    input  logic         ctrl_slow,
    input  logic         ack_we,
    output logic [31:0]  load_o,
    output logic [31:0]  count_o,
    output logic [7:0]   ctrl_o,
    output logic         irq_o
);
    logic [W-1:0] reload_q, cnt_q;
    logic         run_q, period_q, slow_q, irq_q;
    logic         tick, wrap;

    assign tick = slow_q ? slow_tick : fast_tick;
    assign wrap = run_q && tick && (cnt_q == '0);

    // control word storage
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q    <= 1'b0;
            period_q <= 1'b0;
            slow_q   <= 1'b0;
        end else if (ctrl_we) begin
            run_q    <= ctrl_run;
            period_q <= ctrl_period;
            slow_q   <= ctrl_slow;
        end
    end

    // reload value storage
    always_ff @(posedge clk) begin
        if (!rst_n)       reload_q <= '0;
        else if (load_we) reload_q <= load_data;
    end

    // live count: a load write wins, then count down, reload or wrap
    always_ff @(posedge clk) begin
        if (!rst_n)                cnt_q <= '0;
        else if (load_we)          cnt_q <= load_data;
        else if (run_q && tick) begin
            if (cnt_q == '0)       cnt_q <= period_q ? reload_q : '1;
            else                   cnt_q <= cnt_q - 1'b1;
        end
    end

    // interrupt level: set by underflow, cleared by acknowledge
    always_ff @(posedge clk) begin
        if (!rst_n)      irq_q <= 1'b0;
        else if (wrap)   irq_q <= 1'b1;
        else if (ack_we) irq_q <= 1'b0;
    end

    assign load_o  = 32'(reload_q);
    assign count_o = 32'(cnt_q);
    assign ctrl_o  = {run_q, period_q, 2'b00, slow_q, 3'b000};
    assign irq_o   = irq_q;

    p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!(run_q && tick) && !load_we) |=> $stable(cnt_q));
    p_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q && tick && cnt_q != '0 && !load_we) |=> (cnt_q == $past(cnt_q) - 1'b1));
    p_reload_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap && period_q && !load_we) |=> (cnt_q == $past(reload_q)));
    p_wrap_ones_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap && !period_q && !load_we) |=> (&cnt_q));
    p_ack_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_we && !wrap) |=> !irq_q);
    p_irq_src_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_q) |-> $past(wrap));
endmodule

// File: rtl/tmr_up.sv
// Free-running up-counter without interrupt, paced by the fast tick.
// Assumes LO_W <= 32 and FREE_W - LO_W between 1 and 8.
module tmr_up #(
    parameter int FREE_W = 40,
    parameter int LO_W   = 32
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        fast_tick,
    input  logic        en_we,
    input  logic        en_data,
    output logic [31:0] lo_o,
    output logic [31:0] hi_o
);
    localparam int HI_W = FREE_W - LO_W;

    logic [FREE_W-1:0] cnt_q;
    logic              en_q;
    logic [7:0]        hi_bits;

    // enable bit written through the high word
    always_ff @(posedge clk) begin
        if (!rst_n)     en_q <= 1'b0;
        else if (en_we) en_q <= en_data;
    end

    // count one per fast tick while enabled, wrapping at the top
    always_ff @(posedge clk) begin
        if (!rst_n)                 cnt_q <= '0;
        else if (en_q && fast_tick) cnt_q <= cnt_q + 1'b1;
    end

    assign hi_bits = 8'(cnt_q[FREE_W-1:LO_W]);
    assign lo_o    = 32'(cnt_q[LO_W-1:0]);
    assign hi_o    = {23'b0, en_q, hi_bits};

    p_up_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(en_q && fast_tick) |=> $stable(cnt_q));
    p_up_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q && fast_tick) |=> (cnt_q == FREE_W'($past(cnt_q) + 1'b1)));
    initial begin
        assert (HI_W >= 1 && HI_W <= 8);
    end
endmodule

// File: rtl/timer_bank.sv
// Timer bank top: three down-counters (two SHORT_W, one LONG_W) with
// level interrupts and one FREE_W up-counter, behind a word-addressed
// write port and a combinational read port. Assumes single-cycle ticks.
module timer_bank
    import timer_pkg::*;
#(
    parameter int SHORT_W = 16,
    parameter int LONG_W  = 32,
    parameter int FREE_W  = 40,
    parameter int LO_W    = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              slow_tick,
    input  logic              fast_tick,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       wdata,
    output logic [31:0]       rdata,
    output logic [N_DOWN-1:0] irq
);
    logic [N_DOWN-1:0] load_we, ctrl_we, ack_we;
    logic              up_we;
    logic [31:0]       load_rd  [N_DOWN];
    logic [31:0]       count_rd [N_DOWN];
    logic [7:0]        ctrl_rd  [N_DOWN];
    logic [31:0]       up_lo, up_hi;

    tmr_decode #(.NT(N_DOWN)) u_dec (
        .wr_en   (wr_en),
        .addr    (addr),
        .load_we (load_we),
        .ctrl_we (ctrl_we),
        .ack_we  (ack_we),
        .up_we   (up_we)
    );

    for (genvar k = 0; k < N_DOWN; k++) begin : g_down
        localparam int W = (k == N_DOWN - 1) ? LONG_W : SHORT_W;
        tmr_down #(.W(W)) u_tmr (
            .clk         (clk),
            .rst_n       (rst_n),
            .slow_tick   (slow_tick),
            .fast_tick   (fast_tick),
            .load_we     (load_we[k]),
            .load_data   (wdata[W-1:0]),
            .ctrl_we     (ctrl_we[k]),
            .ctrl_run    (wdata[CB_RUN]),
            .ctrl_period (wdata[CB_PERIOD]),
            .ctrl_slow   (wdata[CB_SLOW]),
            .ack_we      (ack_we[k]),
            .load_o      (load_rd[k]),
            .count_o     (count_rd[k]),
            .ctrl_o      (ctrl_rd[k]),
            .irq_o       (irq[k])
        );
    end

    tmr_up #(.FREE_W(FREE_W), .LO_W(LO_W)) u_up (
        .clk       (clk),
        .rst_n     (rst_n),
        .fast_tick (fast_tick),
        .en_we     (up_we),
        .en_data   (wdata[UP_EN_BIT]),
        .lo_o      (up_lo),
        .hi_o      (up_hi)
    );

    // read mux over the word map; unmapped words read zero
    always_comb begin
        rdata = '0;
        if (int'(addr[3:2]) < N_DOWN) begin
            case (int'(addr[1:0]))
                OFS_LOAD:  rdata = load_rd[addr[3:2]];
                OFS_VALUE: rdata = count_rd[addr[3:2]];
                OFS_CTRL:  rdata = 32'(ctrl_rd[addr[3:2]]);
                default:   rdata = '0;
            endcase
        end else if (int'(addr) == ADR_UP_LO) begin
            rdata = up_lo;
        end else if (int'(addr) == ADR_UP_HI) begin
            rdata = up_hi;
        end
    end

    p_unmapped_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (addr[3:1] == 3'b111) |-> (rdata == '0));
endmodule

// File: tb/tb_timer_bank.sv
module tb_timer_bank;
    localparam int SW = 4, LW = 6, FW = 12, LOW = 8;

    logic        clk = 1'b0, rst_n = 1'b0;
    logic        slow_tick = 1'b0, fast_tick = 1'b0, wr_en = 1'b0;
    logic [3:0]  addr = '0;
    logic [31:0] wdata = '0, rdata;
    logic [2:0]  irq;
    int          errors = 0, checks = 0;
    bit          done = 0;

    timer_bank #(.SHORT_W(SW), .LONG_W(LW), .FREE_W(FW), .LO_W(LOW)) dut (
        .clk(clk), .rst_n(rst_n), .slow_tick(slow_tick), .fast_tick(fast_tick),
        .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq));

    always #5 clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk); wr_en = 1'b1; addr = 4'(a); wdata = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic rd(input int a, output logic [31:0] v);
        addr = 4'(a); #1; v = rdata;
    endtask

    task automatic st(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); slow_tick = 1'b1;
            @(negedge clk); slow_tick = 1'b0;
        end
    endtask

    task automatic ft(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); fast_tick = 1'b1;
            @(negedge clk); fast_tick = 1'b0;
        end
    endtask

    // slow ticks until irq[0] rises, capped
    task automatic ticks_to_irq(output int n);
        n = 0;
        while (!irq[0] && n < 40) begin st(1); n++; end
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=expired expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        int n;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        for (int a = 0; a < 16; a++) begin rd(a, v); chk("R1 reset read", v, 0); end
        chk("R1 reset irq", 32'(irq), 0);

        // R2 load while disabled, R4 hold while disabled
        wr(0, 32'h9); rd(1, v); chk("R2 load copies to count", v, 9);
        rd(0, v); chk("R2 load readback", v, 9);
        wr(2, 32'h48); st(3); ft(3); rd(1, v); chk("R4 disabled holds", v, 9);

        // R6 free-run wrap on timer 0
        wr(0, 2); wr(2, 32'h88); st(2); rd(1, v); chk("R4 countdown", v, 0);
        chk("R6 no irq before underflow", 32'(irq[0]), 0);
        st(1); rd(1, v); chk("R6 wrap to ones", v, 15);
        chk("R6 irq on wrap", 32'(irq[0]), 1);
        st(1); rd(1, v); chk("R6 no reload", v, 14);
        chk("R7 irq level held", 32'(irq[0]), 1);
        wr(3, 32'h1234); chk("R7 clear", 32'(irq[0]), 0);

        // R5 periodic sweep over every reload value
        for (int nv = 0; nv < 16; nv++) begin
            wr(2, 32'h48); wr(3, 0); wr(0, nv); wr(2, 32'hC8);
            ticks_to_irq(n); chk("R5 first period", n, nv + 1);
            rd(1, v); chk("R5 reload value", v, nv);
            wr(3, 0); chk("R7 clear after period", 32'(irq[0]), 0);
            ticks_to_irq(n); chk("R5 second period", n, nv + 1);
        end

        // R7 underflow in the same cycle as clear keeps irq
        wr(2, 32'h48); wr(0, 0); wr(2, 32'hC8); wr(3, 0);
        chk("R7 cleared before collision", 32'(irq[0]), 0);
        @(negedge clk); wr_en = 1'b1; addr = 4'd3; slow_tick = 1'b1;
        @(negedge clk); wr_en = 1'b0; slow_tick = 1'b0;
        chk("R7 underflow beats clear", 32'(irq[0]), 1);
        wr(2, 32'h48); wr(3, 0);

        // R3 tick select on timer 1
        wr(4, 5); wr(6, 32'h80); st(2); rd(5, v); chk("R3 fast select ignores slow", v, 5);
        ft(2); rd(5, v); chk("R3 fast select counts fast", v, 3);
        wr(6, 32'hFF); rd(6, v); chk("R3 control readback", v, 32'hC8);
        wr(6, 32'h00); rd(5, v); chk("R4 hold after disable", v, 3);

        // R8 wide timer truncation, period and independence
        wr(8, 32'hFFFF_FFFF); rd(8, v); chk("R8 truncated load", v, 63);
        wr(10, 32'hC8); st(63);
        chk("R8 no irq at 63", 32'(irq), 0);
        st(1); chk("R8 irq only on timer 2", 32'(irq), 32'b100);
        wr(11, 0); chk("R8 clear timer 2", 32'(irq), 0);
        wr(10, 32'h00);

        // R11 unmapped
        wr(14, 32'hFFFF_FFFF); wr(15, 32'hFFFF_FFFF);
        rd(14, v); chk("R11 addr 14 reads zero", v, 0);
        rd(15, v); chk("R11 addr 15 reads zero", v, 0);
        rd(5, v); chk("R11 no side effect", v, 3);
        rd(13, v); chk("R11 up-counter untouched", v, 0);

        // R9 up-counter
        ft(4); rd(12, v); chk("R9 disabled up-counter holds", v, 0);
        wr(13, 32'h100); rd(13, v); chk("R9 enable readback", v, 32'h100);
        ft(5); rd(12, v); chk("R9 counts fast", v, 5);
        st(3); rd(12, v); chk("R9 ignores slow", v, 5);
        ft(251); rd(12, v); chk("R10 low carry", v, 0);
        rd(13, v); chk("R10 high word", v, 32'h101);
        chk("R9 no interrupt", 32'(irq), 0);
        ft(3840); rd(12, v); chk("R10 full wrap low", v, 0);
        rd(13, v); chk("R10 full wrap high", v, 32'h100);
        ft(7); wr(13, 0); ft(2); rd(12, v); chk("R9 disable holds", v, 7);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule